// File: doc/BRIEF.md
# Eight-Channel DAC Code Update Controller

This block is the digital core behind an eight-channel voltage-output converter. A host writes 32-bit frames over a three-wire serial link (serial clock, active-low frame select, data). Every channel keeps two levels of storage. A staging register receives new codes. A live register drives the converter code that leaves the block. Codes move from the staging level to the live level under a frame command, or for a chosen set of channels when the active-low load pin is held low. Four channels (0, 1, 6, 7) are 16 bits wide. The other four are 12 bits wide and are presented zero-extended on the 16-bit code lanes.

The serial pins are oversampled by the block clock through a synchronizer, and bits are captured on the falling edges of the serial clock. An active-low clear pin forces every live register to a clear level chosen by software: zero, midscale or full scale. This forcing reaches the outputs at once, without waiting for a clock edge. The block also presents a per-channel power-down mode and a reference-enable flag to the analog side. Reset leaves all codes at zero and the reference off. The first accepted command switches the reference on.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset every live code is zero, every power-down mode is 00, the reference enable is low, the load mask is all ones and the clear level is zero.
- R2: A frame is 32 bits taken MSB first on falling serial-clock edges while frame select is low. Bits [27:24] are the command, [23:20] the address (0-7 selects a channel, 15 selects all channels, 8-14 select none) and [19:4] the 16-bit data. Command 0 writes the staging register of the addressed channels and leaves the live codes unchanged.
- R3: Command 1 copies the staging register into the live register for the addressed channels.
- R4: Command 2 writes the staging and live registers of the addressed channels together. A 12-bit channel takes data bits [15:12] through [15:4], i.e. the upper 12 data bits.
- R5: Command 3 writes the staging registers of the addressed channels and then copies the staging registers of all eight channels into their live registers.
- R6: If frame select rises before the 32nd bit, the frame has no effect on any register.
- R7: While the load pin is low, each channel whose bit is set in the load mask copies its staging register into its live register. Other channels hold their live codes. Command 6 sets the mask from data [7:0], where bit i selects channel i.
- R8: While the clear pin is low, every code output shows the clear level without waiting for a clock edge, and the live registers take that level. Command 5 chooses the level from data [1:0]: 00 for zero, 01 for midscale (MSB only set), 10 for full scale. The value 11 leaves the choice unchanged.
- R9: Command 4 sets the 2-bit power-down mode output to data [9:8] for every channel i with data bit i set. Power-down never alters any code, and returning a channel to mode 00 leaves its code unchanged.
- R10: The reference enable turns on with the first accepted frame whose command is 0 to 6. Command 7 sets it from data bit 0, and no later command other than 7 changes it.
- R11: Frames with command codes 8 to 15 change no code, mode, mask, clear level or reference state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; bits taken on falling edges |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load pin for masked channels |
| clr_n | input | 1 | Active-low clear pin |
| dac_code_o | output | 128 | Eight 16-bit live codes, channel i in bits [16i+15:16i] |
| pd_mode_o | output | 16 | Eight 2-bit power-down modes, channel i in bits [2i+1:2i] |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
The bench sweeps every channel through the write, update and write-and-update commands. A design that mixed up the 16-bit and 12-bit lanes, or took the wrong 12 data bits, would show wrong values on exactly those channels. Short frames are checked to confirm that a frame aborted early leaves no trace; a receiver that acted on a partial shift would corrupt a channel. The clear pin is sampled between clock edges to catch a design that waits for a clock edge to apply the clear level. The reserved clear selector 11 and the unknown command codes are also exercised. The load mask is checked with a sparse pattern, so a design that ignored the mask would move channels that should hold. Power-down on/off cycles and the reference's first-write turn-on are checked at the ports.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
   localparam int LEAD_PAD = 4;
   localparam int CMD_W    = 4;
   localparam int ADDR_W   = 4;
   localparam int DATA_W   = 16;
   localparam int TAIL_PAD = 4;
   localparam int PAYLOAD_W  = CMD_W + ADDR_W + DATA_W;
   localparam int FRAME_BITS = LEAD_PAD + PAYLOAD_W + TAIL_PAD;

   localparam logic [CMD_W-1:0] CMD_WR_IN      = 4'd0;
   localparam logic [CMD_W-1:0] CMD_UPD        = 4'd1;
   localparam logic [CMD_W-1:0] CMD_WR_UPD     = 4'd2;
   localparam logic [CMD_W-1:0] CMD_WR_UPD_ALL = 4'd3;
   localparam logic [CMD_W-1:0] CMD_PWRDN      = 4'd4;
   localparam logic [CMD_W-1:0] CMD_CLR_SEL    = 4'd5;
   localparam logic [CMD_W-1:0] CMD_LD_MASK    = 4'd6;
   localparam logic [CMD_W-1:0] CMD_REF        = 4'd7;

   localparam logic [1:0] CLR_ZERO = 2'd0;
   localparam logic [1:0] CLR_MID  = 2'd1;
   localparam logic [1:0] CLR_FULL = 2'd2;
endpackage

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
   import dac_ctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk,
   input  logic                 sync_n,
   input  logic                 din,
   output logic                 frame_vld_o,
   output logic [PAYLOAD_W-1:0] payload_o
);
   localparam int SHREG_W = PAYLOAD_W + TAIL_PAD;
   localparam int CNT_W   = $clog2(FRAME_BITS + 1);

   logic [SYNC_STAGES-1:0] sclk_sy, sync_sy, din_sy;
   logic                   sclk_prev;
   logic [SHREG_W-1:0]     shreg;
   logic [CNT_W-1:0]       cnt;
   logic                   fall, sel_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_sy   <= '1;
         sync_sy   <= '1;
         din_sy    <= '0;
         sclk_prev <= 1'b1;
      end else begin
         sclk_sy   <= {sclk_sy[SYNC_STAGES-2:0], sclk};
         sync_sy   <= {sync_sy[SYNC_STAGES-2:0], sync_n};
         din_sy    <= {din_sy[SYNC_STAGES-2:0], din};
         sclk_prev <= sclk_sy[SYNC_STAGES-1];
      end
   end

   assign fall    = sclk_prev && !sclk_sy[SYNC_STAGES-1];
   assign sel_low = !sync_sy[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg       <= '0;
         cnt         <= '0;
         frame_vld_o <= 1'b0;
      end else begin
         frame_vld_o <= sel_low && fall && (cnt == CNT_W'(FRAME_BITS - 1));
         if (!sel_low) begin
            cnt <= '0;
         end else if (fall && cnt < CNT_W'(FRAME_BITS)) begin
            shreg <= {shreg[SHREG_W-2:0], din_sy[SYNC_STAGES-1]};
            cnt   <= cnt + 1'b1;
         end
      end
   end

   assign payload_o = shreg[SHREG_W-1:TAIL_PAD];

   initial assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");

   AST_ONE_FRAME_PER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |=> !frame_vld_o); // R6
endmodule

// File: rtl/dac_chan.sv
module dac_chan
   import dac_ctl_pkg::*;
#(
   parameter int CW    = 16,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             upd_i,
   input  logic             clr_i,
   input  logic [1:0]       clr_sel_i,
   input  logic [CW-1:0]    data_i,
   output logic [OUT_W-1:0] code_o
);
   logic [CW-1:0] in_q, dac_q, clr_v;

   always_comb begin
      case (clr_sel_i)
         CLR_MID:  clr_v = {1'b1, {(CW-1){1'b0}}};
         CLR_FULL: clr_v = '1;
         default:  clr_v = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         dac_q <= '0;
      end else begin
         if (wr_i) in_q <= data_i;
         if (clr_i)      dac_q <= clr_v;
         else if (upd_i) dac_q <= wr_i ? data_i : in_q;
      end
   end

   always_comb begin
      code_o = '0;
      code_o[CW-1:0] = clr_i ? clr_v : dac_q;
   end

   initial assert (CW <= OUT_W && CW >= 2) else $error("channel width out of range");

   AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_i && !clr_i) |=> $stable(dac_q)); // R2
   AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(in_q)); // R3
endmodule

// File: rtl/dac_cfg.sv
module dac_cfg
   import dac_ctl_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_vld_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [9:0]       data_i,
   output logic [NCH-1:0]   ld_mask_o,
   output logic [2*NCH-1:0] pd_mode_o,
   output logic [1:0]       clr_sel_o,
   output logic             ref_en_o
);
   logic armed, known;

   assign known = (cmd_i <= CMD_REF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_mask_o <= '1;
         pd_mode_o <= '0;
         clr_sel_o <= CLR_ZERO;
         ref_en_o  <= 1'b0;
         armed     <= 1'b1;
      end else if (frame_vld_i && known) begin
         armed <= 1'b0;
         if (cmd_i == CMD_REF)       ref_en_o <= data_i[0];
         else if (armed)             ref_en_o <= 1'b1;
         if (cmd_i == CMD_LD_MASK)   ld_mask_o <= data_i[NCH-1:0];
         if (cmd_i == CMD_CLR_SEL && data_i[1:0] != 2'b11) clr_sel_o <= data_i[1:0];
         if (cmd_i == CMD_PWRDN) begin
            for (int i = 0; i < NCH; i++)
               if (data_i[i]) pd_mode_o[2*i +: 2] <= data_i[9:8];
         end
      end
   end

   AST_REF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_en_o && !(frame_vld_i && cmd_i == CMD_REF)) |=> ref_en_o); // R10
   AST_MODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_vld_i && cmd_i == CMD_PWRDN) |=> $stable(pd_mode_o)); // R9
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
   import dac_ctl_pkg::*;
#(
   parameter int                NCH         = 8,
   parameter int                CODE_W      = 16,
   parameter int                NARROW_W    = 12,
   parameter logic [NCH-1:0]    WIDE_MASK   = 8'b1100_0011,
   parameter int                SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk,
   input  logic                  sync_n,
   input  logic                  din,
   input  logic                  ldac_n,
   input  logic                  clr_n,
   output logic [NCH*CODE_W-1:0] dac_code_o,
   output logic [2*NCH-1:0]      pd_mode_o,
   output logic                  ref_en_o
);
   localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

   logic                 frame_vld;
   logic [PAYLOAD_W-1:0] payload;
   logic [CMD_W-1:0]     f_cmd;
   logic [ADDR_W-1:0]    f_addr;
   logic [DATA_W-1:0]    f_data;
   logic [NCH-1:0]       ld_mask;
   logic [1:0]           clr_sel;
   logic                 is_wr, is_upd_one, is_upd_all;

   dac_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
      .frame_vld_o(frame_vld), .payload_o(payload));

   assign {f_cmd, f_addr, f_data} = payload;

   assign is_wr      = frame_vld && (f_cmd == CMD_WR_IN || f_cmd == CMD_WR_UPD ||
                                     f_cmd == CMD_WR_UPD_ALL);
   assign is_upd_one = frame_vld && (f_cmd == CMD_UPD || f_cmd == CMD_WR_UPD);
   assign is_upd_all = frame_vld && (f_cmd == CMD_WR_UPD_ALL);

   dac_cfg #(.NCH(NCH)) u_cfg (
      .clk(clk), .rst_n(rst_n), .frame_vld_i(frame_vld), .cmd_i(f_cmd),
      .data_i(f_data[9:0]), .ld_mask_o(ld_mask), .pd_mode_o(pd_mode_o),
      .clr_sel_o(clr_sel), .ref_en_o(ref_en_o));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int CW = WIDE_MASK[i] ? CODE_W : NARROW_W;
      logic addressed, wr, upd;

      assign addressed = (f_addr == ADDR_ALL) || (f_addr == ADDR_W'(i));
      assign wr  = is_wr && addressed;
      assign upd = (is_upd_one && addressed) || is_upd_all || (!ldac_n && ld_mask[i]);

      dac_chan #(.CW(CW), .OUT_W(CODE_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .wr_i(wr), .upd_i(upd), .clr_i(!clr_n),
         .clr_sel_i(clr_sel), .data_i(f_data[DATA_W-1 -: CW]),
         .code_o(dac_code_o[i*CODE_W +: CODE_W]));
   end

   initial begin
      assert (NCH >= 1 && NCH <= 8) else $error("NCH must be 1..8");
      assert (CODE_W == DATA_W) else $error("CODE_W must match the data field");
      assert (NARROW_W <= CODE_W) else $error("NARROW_W exceeds CODE_W");
   end

   AST_CLEAR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && $past(!clr_n) && $stable(clr_sel)) |-> $stable(dac_code_o)); // R8
   AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && f_cmd[CMD_W-1]) |=> ($stable(pd_mode_o) && $stable(ref_en_o))); // R11
endmodule

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;
   localparam logic [7:0] WIDE = 8'hC3;

   logic clk = 0, rst_n = 0, sclk = 1, sync_n = 1, din = 0, ldac_n = 1, clr_n = 1;
   logic [127:0] dac_code_o;
   logic [15:0]  pd_mode_o;
   logic         ref_en_o;

   int checks = 0, errors = 0;

   logic [15:0] in_m [8];
   logic [15:0] dac_m [8];
   logic [1:0]  pd_m [8];
   logic [7:0]  mask_m;
   logic [1:0]  clr_m;
   logic        ref_m, armed_m;

   always #10 clk = ~clk;

   dac_update_ctrl uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
      .ldac_n(ldac_n), .clr_n(clr_n), .dac_code_o(dac_code_o), .pd_mode_o(pd_mode_o),
      .ref_en_o(ref_en_o));

   function automatic logic [15:0] shown(int ch, logic [15:0] v);
      return WIDE[ch] ? v : {4'h0, v[15:4]};
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_state(string tag);
      for (int i = 0; i < 8; i++)
         chk($sformatf("%s ch%0d code", tag, i), 32'(dac_code_o[16*i +: 16]), 32'(shown(i, dac_m[i])));
      for (int i = 0; i < 8; i++)
         chk($sformatf("%s ch%0d mode", tag, i), 32'(pd_mode_o[2*i +: 2]), 32'(pd_m[i]));
      chk({tag, " ref"}, 32'(ref_en_o), 32'(ref_m));
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift(logic [31:0] f, int n);
      @(negedge clk);
      sync_n = 0;
      for (int b = 0; b < n; b++) begin
         sclk = 1; din = f[31-b]; wait_clk(4);
         sclk = 0; wait_clk(4);
      end
      sclk = 1; wait_clk(4);
      sync_n = 1; wait_clk(10);
   endtask

   task automatic model(logic [3:0] cmd, logic [3:0] addr, logic [15:0] d);
      for (int i = 0; i < 8; i++) begin
         bit s = (addr == 4'hF) || (addr == 4'(i));
         if (s && (cmd == 0 || cmd == 2 || cmd == 3)) in_m[i] = d;
         if (s && cmd == 1) dac_m[i] = in_m[i];
         if (s && cmd == 2) dac_m[i] = d;
         if (cmd == 4 && d[i]) pd_m[i] = d[9:8];
      end
      if (cmd == 3) for (int i = 0; i < 8; i++) dac_m[i] = in_m[i];
      if (cmd == 5 && d[1:0] != 2'b11) clr_m = d[1:0];
      if (cmd == 6) mask_m = d[7:0];
      if (cmd <= 7) begin
         if (cmd == 7) ref_m = d[0];
         else if (armed_m) ref_m = 1;
         armed_m = 0;
      end
   endtask

   task automatic send(logic [3:0] cmd, logic [3:0] addr, logic [15:0] d);
      shift({4'h5, cmd, addr, d, 4'hA}, 32);
      model(cmd, addr, d);
   endtask

   function automatic logic [15:0] clr_level(logic [1:0] s);
      return (s == 2'd1) ? 16'h8000 : (s == 2'd2) ? 16'hFFFF : 16'h0000;
   endfunction

   initial begin
      for (int i = 0; i < 8; i++) begin in_m[i] = 0; dac_m[i] = 0; pd_m[i] = 0; end
      mask_m = 8'hFF; clr_m = 0; ref_m = 0; armed_m = 1;
      wait_clk(5); rst_n = 1; wait_clk(3);

      check_state("R1 reset");

      // R2: staging write leaves codes; first write turns reference on (R10)
      send(0, 0, 16'h1234);
      check_state("R2 write staging");
      chk("R10 ref on after first write", 32'(ref_en_o), 32'd1);

      send(1, 0, 16'h0000);
      check_state("R3 update ch0");

      // R4: sweep write-and-update over every channel
      for (int i = 0; i < 8; i++) begin
         send(2, 4'(i), 16'hA5C3 ^ 16'(i * 16'h1357));
         check_state($sformatf("R4 sweep ch%0d", i));
      end

      send(3, 4'hF, 16'h5A5A);
      check_state("R5 broadcast write-update");
      send(0, 4'hF, 16'h1111);
      send(3, 4'd3, 16'h2222);
      check_state("R5 single write update all");

      // R6: aborted frames of various lengths
      for (int n = 1; n < 32; n += 6) begin
         shift({4'h0, 4'd2, 4'd1, 16'hFFFF, 4'h0}, n);
         check_state($sformatf("R6 short frame %0d bits", n));
      end

      // R7: sparse load mask
      send(6, 0, 16'h0005);
      send(0, 4'hF, 16'h7777);
      check_state("R7 before load");
      @(negedge clk); ldac_n = 0; wait_clk(3); ldac_n = 1; wait_clk(2);
      dac_m[0] = in_m[0]; dac_m[2] = in_m[2];
      check_state("R7 masked load");
      send(6, 0, 16'h00FF);
      @(negedge clk); ldac_n = 0; wait_clk(3); ldac_n = 1; wait_clk(2);
      for (int i = 0; i < 8; i++) dac_m[i] = in_m[i];
      check_state("R7 full mask load");

      // R8: clear levels, observed between edges
      send(5, 0, 16'h0001);
      @(negedge clk); clr_n = 0; #2;
      for (int i = 0; i < 8; i++) dac_m[i] = clr_level(clr_m);
      check_state("R8 midscale immediate");
      wait_clk(2); clr_n = 1; wait_clk(2);
      check_state("R8 midscale held");
      send(5, 0, 16'h0002);
      send(5, 0, 16'h0003);
      @(negedge clk); clr_n = 0; #2;
      for (int i = 0; i < 8; i++) dac_m[i] = clr_level(clr_m);
      check_state("R8 full scale, 11 ignored");
      wait_clk(2); clr_n = 1; wait_clk(2);
      send(5, 0, 16'h0000);
      @(negedge clk); clr_n = 0; #2;
      for (int i = 0; i < 8; i++) dac_m[i] = 0;
      check_state("R8 zero");
      wait_clk(2); clr_n = 1; wait_clk(2);

      // R9: power-down keeps codes
      send(2, 4'd1, 16'h4321);
      send(4, 0, 16'h0212);
      check_state("R9 power down ch1 ch4");
      send(4, 0, 16'h0302);
      check_state("R9 mode change ch1");
      send(4, 0, 16'h0002);
      check_state("R9 ch1 back to normal");

      // R11: unknown commands and unused addresses
      for (int c = 8; c < 16; c++) begin
         send(4'(c), 4'd0, 16'hFFFF);
         check_state($sformatf("R11 cmd %0d", c));
      end
      send(2, 4'd9, 16'hBEEF);
      check_state("R2 unused address");

      // R10: explicit reference control
      send(7, 0, 16'h0000);
      check_state("R10 ref off");
      send(0, 4'd5, 16'h0F0F);
      check_state("R10 stays off");
      send(7, 0, 16'h0001);
      check_state("R10 ref on again");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule